// File: doc/BRIEF.md
# Clock-Synchronous Full-Duplex Serial Transceiver

This block is an 8-bit serial port that acts as clock master. It drives a serial clock derived from the system clock and shifts a byte out on its data output while it shifts a byte in on its data input, both on that clock. A host talks to it through four byte-wide locations: a control word, a status word, a transmit holding byte and a receive holding byte. Behind them sit a shift register and a small transfer controller. The controller decides, at the end of each frame, whether to keep the clock running or to stop.

When both directions are enabled, a byte written to the transmit holding location starts a frame. If the host refills the holding location before the last bit of a frame is sampled, the next frame follows with no gap. The clock stops when no byte is waiting, or when a received byte could not be stored because the previous one was still unread. Entry into full-duplex operation is gated by a clean state. Leaving that operation can never produce an extra clock edge. A soft-reset bit quiets the controller and the shift register and leaves the enables and the holding bytes as they were.

Top module: `sync_xcvr`

## Requirements
- R1: After reset, control (address 0) reads 0x00, status (address 1) reads 0x01, sclk is high and txd is high. Control bits: bit0 transmit enable, bit1 receive enable, bit2 soft reset. Status bits: bit0 buffer empty, bit1 transmit busy, bit2 receive full, bit3 overrun.
- R2: With the transmit enable set, a write to address 2 starts a frame of exactly 8 sclk periods. sclk idles high and each period is 2*HALF_DIV system clocks. txd sends the byte MSB first and changes only on sclk falling edges.
- R3: A write to address 2 clears the buffer-empty bit. The bit is set again when the byte moves into the shift register. If a new byte is written before the 8th rising edge of a frame, the next frame follows with one normal sclk period between the 8th and 9th rising edges.
- R4: If the buffer is empty at the 8th rising edge, sclk stays high from then on and transmit busy drops to 0. Transmit busy is 1 while a frame runs or a byte is waiting.
- R5: With the receive enable set, rxd is sampled on sclk rising edges, MSB first. The byte is stored at address 3 when the frame ends, and receive full is set. A read of address 3 clears receive full.
- R6: A frame that ends while receive full is 1 sets overrun, leaves address 3 unchanged and stops sclk even if a byte is waiting. No frame starts while overrun and the receive enable are both set. Overrun is cleared only by writing address 1 with bit3 = 0.
- R7: A control write that sets both enables takes effect only if both enables were 0 and busy, receive full and overrun were all 0. Otherwise the enables keep their old values.
- R8: Clearing the receive enable and then the transmit enable, or clearing both in one write, gives no sclk edge. Clearing the transmit enable mid-frame aborts the frame with sclk high and no byte stored.
- R9: While control bit2 is 1, the transfer controller is idle with sclk high and the shift register is cleared. The enables and both holding bytes are unchanged. After bit2 returns to 0, a new frame sends and receives correctly.
- R10: With only the transmit enable set, frames run as usual, but receive full and overrun are never set and address 3 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (side effects only) |
| addr | input | 2 | Host location: 0 control, 1 status, 2 transmit byte, 3 receive byte |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data for the addressed location |
| sclk | output | 1 | Serial clock, idles high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The hardest state to reach is an overrun with a byte already waiting. The bench must refill the transmit byte during the first frame and then deliberately leave the first received byte unread. The second frame then ends against a full receive location. The bench then writes another transmit byte to show that the block stays silent. It also writes a 1 to the overrun bit to show the flag survives. Only then does it read, clear the flag and watch the waiting frame run.

// File: rtl/sync_xcvr_pkg.sv
package sync_xcvr_pkg;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TDR  = 2'd2;
  localparam logic [1:0] ADDR_RDR  = 2'd3;

  localparam int CTL_TX   = 0;
  localparam int CTL_RX   = 1;
  localparam int CTL_SRST = 2;

  localparam int ST_EMPTY = 0;
  localparam int ST_BUSY  = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_OVR   = 3;

  typedef enum logic {ENG_IDLE, ENG_RUN} engState_t;

  typedef struct packed {
    logic loadShift;
    logic shiftIn;
    logic driveOut;
    logic captureRx;
    logic writeTdr;
    logic clearShift;
  } dpStrobe_t;

endpackage

// File: rtl/sync_xcvr_ctrl.sv
module sync_xcvr_ctrl
  import sync_xcvr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [3:0] hostBits,
  output dpStrobe_t  strb,
  output logic       sclk,
  output logic       txEn,
  output logic       rxEn,
  output logic       softRst,
  output logic       bufEmpty,
  output logic       txBusy,
  output logic       rxFull,
  output logic       overrun
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  engState_t        state;
  logic [CNT_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sclkR;

  logic wrCtl, wrStat, wrTdr, rdRdr;
  logic wantBoth, entryOk, ctlAccept;
  logic startReq, runStep, fallNow, riseNow, frameEnd, stopNow, reload;
  logic abortNow;

  assign wrCtl  = wrEn && (addr == ADDR_CTL);
  assign wrStat = wrEn && (addr == ADDR_STAT);
  assign wrTdr  = wrEn && (addr == ADDR_TDR);
  assign rdRdr  = rdEn && (addr == ADDR_RDR);

  assign txBusy = (state == ENG_RUN) || !bufEmpty;

  // full-duplex entry is only taken from a clean, fully disabled state
  assign wantBoth  = hostBits[CTL_TX] && hostBits[CTL_RX];
  assign entryOk   = !txEn && !rxEn && !txBusy && !rxFull && !overrun;
  assign ctlAccept = !wantBoth || entryOk;

  assign abortNow = softRst || ((state == ENG_RUN) && !txEn);
  assign startReq = (state == ENG_IDLE) && txEn && !softRst && !bufEmpty
                    && !(rxEn && overrun);
  assign runStep  = (state == ENG_RUN) && !abortNow && (halfCnt == CNT_LAST);
  assign fallNow  = runStep && sclkR;
  assign riseNow  = runStep && !sclkR;
  assign frameEnd = riseNow && (bitCnt == BIT_LAST);
  assign stopNow  = bufEmpty || (rxEn && (overrun || rxFull));
  assign reload   = frameEnd && !stopNow;

  always_comb begin
    strb            = '0;
    strb.loadShift  = startReq || reload;
    strb.shiftIn    = riseNow;
    strb.driveOut   = fallNow;
    strb.captureRx  = frameEnd && rxEn && !rxFull;
    strb.writeTdr   = wrTdr;
    strb.clearShift = softRst;
  end

  assign sclk = sclkR;

  // host-visible control and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn     <= 1'b0;
      rxEn     <= 1'b0;
      softRst  <= 1'b0;
      bufEmpty <= 1'b1;
      rxFull   <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (wrCtl) begin
        softRst <= hostBits[CTL_SRST];
        if (ctlAccept) begin
          txEn <= hostBits[CTL_TX];
          rxEn <= hostBits[CTL_RX];
        end
      end
      if (wrTdr)               bufEmpty <= 1'b0;
      else if (strb.loadShift) bufEmpty <= 1'b1;
      if (strb.captureRx)      rxFull <= 1'b1;
      else if (rdRdr)          rxFull <= 1'b0;
      if (frameEnd && rxEn && rxFull)        overrun <= 1'b1;
      else if (wrStat && !hostBits[ST_OVR])  overrun <= 1'b0;
    end
  end

  // transfer engine: clock generation and frame sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ENG_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclkR   <= 1'b1;
    end else if (abortNow) begin
      state   <= ENG_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclkR   <= 1'b1;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (startReq) begin
            state   <= ENG_RUN;
            halfCnt <= '0;
            bitCnt  <= '0;
          end
        end
        ENG_RUN: begin
          if (halfCnt == CNT_LAST) begin
            halfCnt <= '0;
            if (sclkR) begin
              sclkR <= 1'b0;
            end else begin
              sclkR <= 1'b1;
              if (bitCnt == BIT_LAST) begin
                bitCnt <= '0;
                if (stopNow) state <= ENG_IDLE;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sync_xcvr_datapath.sv
module sync_xcvr_datapath
  import sync_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] tdr,
  output logic [DATA_W-1:0] rdr
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[DATA_W-2:0], rxd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tdr      <= '0;
      rdr      <= '0;
      shiftReg <= '0;
      txd      <= 1'b1;
    end else begin
      if (strb.writeTdr)  tdr <= wrData;
      if (strb.captureRx) rdr <= shiftNext;
      if (strb.clearShift) begin
        shiftReg <= '0;
        txd      <= 1'b1;
      end else begin
        if (strb.loadShift)    shiftReg <= tdr;
        else if (strb.shiftIn) shiftReg <= shiftNext;
        // output bit moves only on falling serial clock edges
        if (strb.driveOut)     txd <= shiftReg[DATA_W-1];
      end
    end
  end

endmodule

// File: rtl/sync_xcvr.sv
module sync_xcvr
  import sync_xcvr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sclk,
  output logic              txd,
  input  logic              rxd
);

  dpStrobe_t         strb;
  logic              txEn, rxEn, softRst;
  logic              bufEmpty, txBusy, rxFull, overrun;
  logic [DATA_W-1:0] tdr, rdr;

  sync_xcvr_ctrl #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .hostBits(wrData[3:0]), .strb(strb), .sclk(sclk),
    .txEn(txEn), .rxEn(rxEn), .softRst(softRst),
    .bufEmpty(bufEmpty), .txBusy(txBusy), .rxFull(rxFull), .overrun(overrun)
  );

  sync_xcvr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rxd(rxd),
    .txd(txd), .tdr(tdr), .rdr(rdr)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTL: begin
        rdData[CTL_TX]   = txEn;
        rdData[CTL_RX]   = rxEn;
        rdData[CTL_SRST] = softRst;
      end
      ADDR_STAT: begin
        rdData[ST_EMPTY] = bufEmpty;
        rdData[ST_BUSY]  = txBusy;
        rdData[ST_FULL]  = rxFull;
        rdData[ST_OVR]   = overrun;
      end
      ADDR_TDR: rdData = tdr;
      default:  rdData = rdr;
    endcase
  end

endmodule

// File: rtl/sync_xcvr_checker.sv
module sync_xcvr_checker (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic txEn,
  input logic rxEn,
  input logic softRst,
  input logic txBusy,
  input logic rxFull,
  input logic overrun
);

  // R6: a flagged overrun with receive enabled keeps the clock parked high
  assert_overrun_halts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && rxEn && $past(rxEn)) |-> sclk);

  // R6: overrun only rises from a frame ending against a full receive byte
  assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(rxEn) && $past(rxFull)));

  // R7: both enables only appear together from a clean disabled state
  assert_entry_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && rxEn && !($past(txEn) && $past(rxEn))) |->
      (!$past(txEn) && !$past(rxEn) && !$past(txBusy) && !$past(rxFull) && !$past(overrun)));

  // R8: once transmit is disabled the clock returns high and stays there
  assert_exit_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!txEn && !$past(txEn)) |-> sclk);

  // R9: an asserted soft reset holds the clock idle
  assert_softrst_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && $past(softRst)) |-> sclk);

  // R5 / R10: a stored byte appears on a rising clock edge with receive enabled
  assert_capture_rx_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> (sclk && $past(rxEn)));

endmodule

bind sync_xcvr sync_xcvr_checker chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .txEn(txEn), .rxEn(rxEn),
  .softRst(softRst), .txBusy(txBusy), .rxFull(rxFull), .overrun(overrun)
);

// File: tb/sync_xcvr_test.sv
`timescale 1ns/1ps
module sync_xcvr_test;

  localparam int HALF = 2;
  localparam int PERIOD_NS = 2 * HALF * 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn, rdEn;
  logic [1:0] addr;
  logic [7:0] wrData, rdData;
  logic       sclk, txd, rxd;

  always #4 clk = ~clk;

  sync_xcvr #(.DATA_W(8), .HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sclk(sclk), .txd(txd), .rxd(rxd)
  );

  int total = 0;
  int bad = 0;

  // serial slave model
  int         riseCount = 0;
  logic [7:0] gotTx [4];
  logic [7:0] slave [4];
  time        riseT [32];

  function automatic logic slaveBit(int n);
    if (n / 8 < 4) return slave[n / 8][7 - (n % 8)];
    return 1'b1;
  endfunction

  always @(posedge sclk) begin
    if (rstN === 1'b1) begin
      if (riseCount / 8 < 4) gotTx[riseCount / 8] = {gotTx[riseCount / 8][6:0], txd};
      if (riseCount < 32) riseT[riseCount] = $time;
      riseCount = riseCount + 1;
    end
  end

  always @(negedge sclk) begin
    if (rstN === 1'b1) rxd = slaveBit(riseCount);
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRises(input int n);
    for (int i = 0; i < 5000 && riseCount < n; i++) @(negedge clk);
    idle(4);
  endtask

  task automatic waitEmpty();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      hostRead(2'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic arm(input logic [7:0] s0, input logic [7:0] s1, input logic [7:0] s2);
    riseCount = 0;
    for (int i = 0; i < 4; i++) gotTx[i] = 8'h00;
    slave[0] = s0; slave[1] = s1; slave[2] = s2; slave[3] = 8'hFF;
  endtask

  logic [7:0] rd;

  task automatic tReset();
    hostRead(2'd0, rd); check("R1 control after reset", rd, 8'h00);
    hostRead(2'd1, rd); check("R1 status after reset", rd, 8'h01);
    check("R1 sclk idle", sclk, 1);
    check("R1 txd idle", txd, 1);
  endtask

  task automatic tSingle();
    hostWrite(2'd0, 8'h03);
    arm(8'h5A, 8'hFF, 8'hFF);
    hostWrite(2'd2, 8'hC3);
    waitRises(8);
    idle(20);
    check("R4 eight clocks then stop", riseCount, 8);
    check("R4 sclk parked high", sclk, 1);
    check("R2 byte sent MSB first", gotTx[0], 8'hC3);
    check("R2 serial period", int'(riseT[1] - riseT[0]), PERIOD_NS);
    hostRead(2'd1, rd); check("R5 status after frame", rd, 8'h05);
    hostRead(2'd3, rd); check("R5 received byte", rd, 8'h5A);
    hostRead(2'd1, rd); check("R5 read clears full", rd, 8'h01);
  endtask

  task automatic tStream();
    arm(8'h81, 8'h7E, 8'hFF);
    hostWrite(2'd2, 8'h96);
    waitEmpty();
    hostWrite(2'd2, 8'h3C);
    hostRead(2'd1, rd); check("R3 write clears empty", rd[0], 0);
    check("R4 busy while byte waits", rd[1], 1);
    waitRises(8);
    hostRead(2'd3, rd); check("R3 first streamed byte", rd, 8'h81);
    waitRises(16);
    idle(20);
    check("R3 two frames", riseCount, 16);
    check("R3 no gap between frames", int'(riseT[8] - riseT[7]), PERIOD_NS);
    check("R3 tx frame 0", gotTx[0], 8'h96);
    check("R3 tx frame 1", gotTx[1], 8'h3C);
    hostRead(2'd1, rd); check("R3 status after stream", rd, 8'h05);
    hostRead(2'd3, rd); check("R5 second streamed byte", rd, 8'h7E);
  endtask

  task automatic tOverrun();
    arm(8'h11, 8'h22, 8'hE7);
    hostWrite(2'd2, 8'hA5);
    waitEmpty();
    hostWrite(2'd2, 8'h5A);
    waitRises(16);
    idle(10);
    hostRead(2'd1, rd); check("R6 overrun flagged", rd, 8'h0D);
    check("R6 clocks after overrun", riseCount, 16);
    hostWrite(2'd2, 8'h0F);
    idle(60);
    check("R6 no start while overrun", riseCount, 16);
    hostRead(2'd1, rd); check("R6 status blocked", rd, 8'h0E);
    hostRead(2'd3, rd); check("R6 old byte kept", rd, 8'h11);
    hostWrite(2'd1, 8'h08);
    idle(20);
    hostRead(2'd1, rd); check("R6 writing 1 keeps overrun", rd[3], 1);
    check("R6 still blocked", riseCount, 16);
    hostWrite(2'd1, 8'h00);
    waitRises(24);
    idle(20);
    check("R6 resumes after clear", riseCount, 24);
    check("R6 pending byte sent", gotTx[2], 8'h0F);
    hostRead(2'd1, rd); check("R6 clean status", rd, 8'h05);
    hostRead(2'd3, rd); check("R6 new byte stored", rd, 8'hE7);
  endtask

  task automatic tMode();
    hostWrite(2'd0, 8'h01);
    hostRead(2'd0, rd); check("R7 single transmit accepted", rd, 8'h01);
    hostWrite(2'd0, 8'h03);
    hostRead(2'd0, rd); check("R7 entry from single rejected", rd, 8'h01);
    hostWrite(2'd0, 8'h00);
    hostWrite(2'd0, 8'h03);
    hostRead(2'd0, rd); check("R7 clean entry accepted", rd, 8'h03);
    arm(8'h6C, 8'hFF, 8'hFF);
    hostWrite(2'd2, 8'h44);
    waitRises(8);
    idle(10);
    hostWrite(2'd0, 8'h00);
    hostWrite(2'd0, 8'h03);
    hostRead(2'd0, rd); check("R7 entry with full rejected", rd, 8'h00);
    hostRead(2'd3, rd); check("R5 byte before entry", rd, 8'h6C);
    hostWrite(2'd0, 8'h03);
    hostRead(2'd0, rd); check("R7 entry after read", rd, 8'h03);
  endtask

  task automatic tExit();
    int r;
    arm(8'h24, 8'hFF, 8'hFF);
    hostWrite(2'd2, 8'h99);
    waitRises(8);
    idle(10);
    hostRead(2'd3, rd);
    riseCount = 0;
    hostWrite(2'd0, 8'h01);
    idle(40);
    hostWrite(2'd0, 8'h00);
    idle(40);
    check("R8 receive then transmit off", riseCount, 0);
    check("R8 sclk high after exit", sclk, 1);
    hostWrite(2'd0, 8'h03);
    arm(8'h3A, 8'hFF, 8'hFF);
    hostWrite(2'd2, 8'h66);
    waitRises(8);
    idle(10);
    hostRead(2'd3, rd);
    riseCount = 0;
    hostWrite(2'd0, 8'h00);
    idle(40);
    check("R8 both off together", riseCount, 0);
    hostWrite(2'd0, 8'h03);
    arm(8'h55, 8'hFF, 8'hFF);
    hostWrite(2'd2, 8'hF0);
    waitRises(3);
    hostWrite(2'd0, 8'h00);
    idle(4);
    check("R8 abort parks sclk", sclk, 1);
    r = riseCount;
    idle(60);
    check("R8 no clocks after abort", riseCount, r);
    hostRead(2'd1, rd); check("R8 abort stores nothing", rd, 8'h01);
  endtask

  task automatic tSoftReset();
    int r;
    hostWrite(2'd0, 8'h03);
    arm(8'hB4, 8'hFF, 8'hFF);
    hostWrite(2'd2, 8'h2D);
    waitRises(3);
    hostWrite(2'd0, 8'h07);
    idle(4);
    check("R9 sclk high in soft reset", sclk, 1);
    r = riseCount;
    idle(60);
    check("R9 no clocks in soft reset", riseCount, r);
    hostRead(2'd0, rd); check("R9 enables kept", rd, 8'h07);
    hostRead(2'd2, rd); check("R9 transmit byte kept", rd, 8'h2D);
    hostRead(2'd3, rd); check("R9 receive byte kept", rd, 8'h3A);
    hostRead(2'd1, rd); check("R9 engine idle", rd, 8'h01);
    hostWrite(2'd0, 8'h03);
    idle(40);
    check("R9 no restart on release", riseCount, r);
    arm(8'hC8, 8'hFF, 8'hFF);
    hostWrite(2'd2, 8'h71);
    waitRises(8);
    idle(10);
    check("R9 clean frame sent", gotTx[0], 8'h71);
    hostRead(2'd3, rd); check("R9 clean frame received", rd, 8'hC8);
  endtask

  task automatic tTxOnly();
    hostWrite(2'd0, 8'h00);
    hostWrite(2'd0, 8'h01);
    arm(8'hFF, 8'h0A, 8'hFF);
    hostWrite(2'd2, 8'h5B);
    waitEmpty();
    hostWrite(2'd2, 8'hA4);
    waitRises(16);
    idle(20);
    check("R10 frames run", riseCount, 16);
    check("R10 tx frame 0", gotTx[0], 8'h5B);
    check("R10 tx frame 1", gotTx[1], 8'hA4);
    hostRead(2'd1, rd); check("R10 no full no overrun", rd, 8'h01);
    hostRead(2'd3, rd); check("R10 receive byte unchanged", rd, 8'hC8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = 2'd0; wrData = 8'h00; rxd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      gotTx[i] = 8'h00;
      slave[i] = 8'hFF;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    tReset();
    tSingle();
    tStream();
    tOverrun();
    tMode();
    tExit();
    tSoftReset();
    tTxOnly();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule